// File: doc/BRIEF.md
# Cache Control Register Unit

This block holds the control word and the two configuration words that describe a core's instruction and data caches. Software reaches them through a 32-bit register port. Each access carries an offset, a size code and a write flag. Reads return their data one cycle after the request. The control word holds a 2-bit state field for each cache, a freeze-on-interrupt enable for each cache, and a set of plain option bits. Some write-only and status bits are cleared whenever the word is written, so they always read back as zero.

The core pulses an interrupt-taken strobe. On that strobe, each cache whose freeze enable is set and whose state is enabled moves to the frozen state. The two state fields are driven out so that the cache logic can follow them. The configuration words are constants that software can read but cannot write.

Top module: `cache_ctrl_regs`

## Requirements
- R1: After reset the control word reads 0, and both `icache_state` and `dcache_state` are 2'b00.
- R2: A 32-bit write to offset 0x00 stores the control word. Bits [1:0] drive `icache_state` and bits [3:2] drive `dcache_state`. The state codes are 00 = off, 01 = frozen and 11 = on.
- R3: When `irq_taken` is high and control bit 4 is set, an instruction-cache state of 11 becomes 01 at the next edge. Any other instruction-cache state is left unchanged.
- R4: When `irq_taken` is high and control bit 5 is set, a data-cache state of 11 becomes 01 at the next edge. Any other data-cache state is left unchanged.
- R5: When the freeze enable for a cache is clear, `irq_taken` leaves that cache's state unchanged.
- R6: On a control write, bits 14, 15, 16, 21 and 22 are stored as 0. Bit 23 and every other bit are stored as written.
- R7: Offset 0x04 reads 0x10220000 and offset 0x08 reads 0x18220000. Writes to either offset change nothing.
- R8: Only size code 2'b10 (32-bit) takes effect. A write with any other size is dropped, and a read with any other size returns 0.
- R9: A read of an offset other than 0x00, 0x04 or 0x08 returns 0, and a write to such an offset has no effect.
- R10: Read data appears on `rd_data` at the edge after the read request. It then holds until the next read.
- R11: When a control write and `irq_taken` fall in the same cycle, the freeze rule is applied to the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access size code; 2'b10 means 32-bit |
| req_wdata | input | 32 | Write data |
| irq_taken | input | 1 | Strobe from the core: an interrupt was taken |
| rd_data | output | 32 | Registered read data |
| icache_state | output | 2 | Current instruction-cache state field |
| dcache_state | output | 2 | Current data-cache state field |

## Verification
The freeze rule is exercised with each cache in the on, off and unused 10 states, and with its freeze enable both set and clear. These cases show that only the on state moves, and only for the cache whose own enable is set. Two all-ones writes check the write filter: one to the control word, to separate filtered bits from stored bits, and one to a configuration offset, to show that the write is ignored. A write issued in the same cycle as the interrupt strobe shows that the freeze acts on the new value and not on the old one. Accesses with sub-word sizes and accesses to unmapped offsets are each followed by a read of the control word, so that any unwanted side effect would be seen.

// File: rtl/ccr_pkg.sv
// Package: shared constants and types for the cache control register unit.
// Assumes a 32-bit register port and two caches (instruction, data).
package ccr_pkg;
    localparam int DATA_W      = 32;
    localparam int NUM_CACHES  = 2;           // index 0 = instruction, 1 = data
    localparam int FLD_W       = 2;           // width of one state field
    localparam int FRZ_BASE    = 4;           // freeze enable of cache i at FRZ_BASE+i
    localparam logic [1:0] SIZE_WORD = 2'b10; // only size that takes effect

    localparam logic [FLD_W-1:0] ST_OFF    = 2'b00;
    localparam logic [FLD_W-1:0] ST_FROZEN = 2'b01;
    localparam logic [FLD_W-1:0] ST_ON     = 2'b11;

    // Bits cleared on every control write (pending flags, flush, burst).
    localparam logic [DATA_W-1:0] WR_CLEAR_MASK =
        (32'h1 << 14) | (32'h1 << 15) | (32'h1 << 16) |
        (32'h1 << 21) | (32'h1 << 22);

    // Byte offsets of the three registers.
    localparam int OFS_CTRL = 0;
    localparam int OFS_ICFG = 4;
    localparam int OFS_DCFG = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_ICFG = 2'd2,
        SEL_DCFG = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/ccr_decode.sv
// Module: access decoder.
// Turns one request into a control-word write enable and a read select.
// Assumes the request is valid for a single cycle; wrong size or unmapped
// offset yields no write and a SEL_NONE read.
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              wr_ctrl,
    output logic              rd_en,
    output rd_sel_e           rd_sel
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ICFG = ADDR_W'(OFS_ICFG);
    localparam logic [ADDR_W-1:0] A_DCFG = ADDR_W'(OFS_DCFG);

    logic size_ok;
    rd_sel_e target;

    // Purpose: map the offset to a register target.
    always_comb begin
        unique case (req_addr)
            A_CTRL:  target = SEL_CTRL;
            A_ICFG:  target = SEL_ICFG;
            A_DCFG:  target = SEL_DCFG;
            default: target = SEL_NONE;
        endcase
    end

    // Purpose: qualify by size and direction.
    always_comb begin
        size_ok = (req_size == SIZE_WORD);
        wr_ctrl = req_valid && req_write && size_ok && (target == SEL_CTRL);
        rd_en   = req_valid && !req_write;
        rd_sel  = size_ok ? target : SEL_NONE;
    end
endmodule

// File: rtl/ccr_ctrl_word.sv
// Module: control word storage with write filter and interrupt freeze.
// The write (filtered) is applied first; each cache's freeze rule is then
// evaluated on that value. Only the "on" state moves to "frozen".
module ccr_ctrl_word
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_taken,
    output logic [DATA_W-1:0] ctrl_q
);
    localparam int FLD_TOP = NUM_CACHES * FLD_W;

    logic [DATA_W-1:0]                  after_wr;
    logic [NUM_CACHES-1:0][FLD_W-1:0]   fld_next;
    logic [DATA_W-1:0]                  ctrl_d;

    // Purpose: apply a software write with write-only bits cleared.
    always_comb begin
        after_wr = wr_en ? (wdata & ~WR_CLEAR_MASK) : ctrl_q;
    end

    // One freeze stage per cache.
    for (genvar i = 0; i < NUM_CACHES; i++) begin : g_cache
        logic frz_en;
        logic [FLD_W-1:0] cur;
        assign frz_en      = after_wr[FRZ_BASE + i];
        assign cur         = after_wr[i*FLD_W +: FLD_W];
        assign fld_next[i] = (irq_taken && frz_en && cur == ST_ON) ? ST_FROZEN : cur;
    end

    // Purpose: reassemble the next control word.
    always_comb begin
        ctrl_d = {after_wr[DATA_W-1:FLD_TOP], fld_next};
    end

    // Purpose: control word register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    AST_IC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken && !wr_en && ctrl_q[FRZ_BASE] && ctrl_q[1:0] == ST_ON
        |=> ctrl_q[1:0] == ST_FROZEN); // R3
    AST_DC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken && !wr_en && ctrl_q[FRZ_BASE+1] && ctrl_q[3:2] == ST_ON
        |=> ctrl_q[3:2] == ST_FROZEN); // R4
    AST_IC_NOFREEZE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !ctrl_q[FRZ_BASE] |=> $stable(ctrl_q[1:0])); // R5
    AST_IC_ONLY_ON_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && ctrl_q[1:0] != ST_ON |=> $stable(ctrl_q[1:0])); // R3
    AST_FILTERED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q & WR_CLEAR_MASK) == '0); // R6
    AST_WR_FREEZE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && irq_taken && wdata[FRZ_BASE] && wdata[1:0] == ST_ON
        |=> ctrl_q[1:0] == ST_FROZEN); // R11
endmodule

// File: rtl/ccr_read_port.sv
// Module: registered read data path.
// Loads on every read request (SEL_NONE gives 0) and holds otherwise.
module ccr_read_port
    import ccr_pkg::*;
#(
    parameter logic [DATA_W-1:0] ICFG_VALUE = 32'h1022_0000,
    parameter logic [DATA_W-1:0] DCFG_VALUE = 32'h1822_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  rd_sel_e           rd_sel,
    input  logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] rd_mux;

    // Purpose: select the word being read.
    always_comb begin
        unique case (rd_sel)
            SEL_CTRL: rd_mux = ctrl_q;
            SEL_ICFG: rd_mux = ICFG_VALUE;
            SEL_DCFG: rd_mux = DCFG_VALUE;
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: one-cycle read latency register.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10
    AST_RD_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_sel == SEL_NONE |=> rd_data == '0); // R9
endmodule

// File: rtl/cache_ctrl_regs.sv
// Module: cache control register unit (top).
// Holds the cache control word and two fixed configuration words behind a
// 32-bit register port, and exports the per-cache state fields.
// Assumes single-cycle requests; reads return data one cycle later.
module cache_ctrl_regs
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [31:0] ICFG_VALUE = 32'h1022_0000,
    parameter logic [31:0] DCFG_VALUE = 32'h1822_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              irq_taken,
    output logic [31:0]       rd_data,
    output logic [1:0]        icache_state,
    output logic [1:0]        dcache_state
);
    logic              wr_ctrl;
    logic              rd_en;
    rd_sel_e           rd_sel;
    logic [DATA_W-1:0] ctrl_q;

    ccr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .wr_ctrl   (wr_ctrl),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel)
    );

    ccr_ctrl_word u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ctrl),
        .wdata     (req_wdata),
        .irq_taken (irq_taken),
        .ctrl_q    (ctrl_q)
    );

    ccr_read_port #(.ICFG_VALUE(ICFG_VALUE), .DCFG_VALUE(DCFG_VALUE)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .ctrl_q  (ctrl_q),
        .rd_data (rd_data)
    );

    // Purpose: export the state fields.
    always_comb begin
        icache_state = ctrl_q[1:0];
        dcache_state = ctrl_q[3:2];
    end

    AST_BAD_SIZE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_size != SIZE_WORD && !irq_taken
        |=> $stable(ctrl_q)); // R8
    AST_BAD_SIZE_RD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_size != SIZE_WORD
        |=> rd_data == '0); // R8
    AST_CFG_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && !irq_taken &&
        (req_addr == ADDR_W'(OFS_ICFG) || req_addr == ADDR_W'(OFS_DCFG))
        |=> $stable(ctrl_q)); // R7
    AST_CFG_RD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_size == SIZE_WORD &&
        req_addr == ADDR_W'(OFS_ICFG) |=> rd_data == ICFG_VALUE); // R7
endmodule

// File: tb/cache_ctrl_regs_tb.sv
module cache_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, irq_taken;
    logic [7:0]  req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic [31:0] rd_data;
    logic [1:0]  icache_state, dcache_state;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_issued;
    logic [31:0] model;

    localparam logic [31:0] CLR = 32'h0061_C000;

    always #4 clk = ~clk; // 125 MHz

    cache_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .irq_taken(irq_taken), .rd_data(rd_data),
        .icache_state(icache_state), .dcache_state(dcache_state)
    );

    // Monitor: note reads latched at an edge, compare at the next low phase.
    always @(posedge clk) rd_issued <= rst_n && req_valid && !req_write;

    always @(negedge clk) begin
        if (rd_issued) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rd_data !== e) begin
                n_fail++;
                $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, e);
            end
        end
    end

    function automatic logic [31:0] freeze(input logic [31:0] v);
        logic [31:0] r;
        r = v;
        if (r[4] && r[1:0] == 2'b11) r[1:0] = 2'b01;
        if (r[5] && r[3:2] == 2'b11) r[3:2] = 2'b01;
        return r;
    endfunction

    // Driver: one request per cycle, entered and left at a falling edge.
    task automatic acc(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input bit irq, input logic [31:0] exp_rd,
                       input string t);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        req_wdata = d; irq_taken = irq;
        if (wr && sz == 2'b10 && a == 8'h00) model = d & ~CLR;
        if (irq) model = freeze(model);
        if (!wr) begin exp_q.push_back(exp_rd); tag_q.push_back(t); end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; irq_taken = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit irq = 0);
        acc(1'b1, a, 2'b10, d, irq, 32'h0, "");
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t,
                      input logic [1:0] sz = 2'b10);
        acc(1'b0, a, sz, 32'h0, 1'b0, e, t);
    endtask

    task automatic pulse_irq();
        irq_taken = 1'b1;
        model = freeze(model);
        @(negedge clk);
        irq_taken = 1'b0;
    endtask

    task automatic chk_state(input string t);
        n_tests++;
        if (icache_state !== model[1:0] || dcache_state !== model[3:2]) begin
            n_fail++;
            $display("FAIL %s state actual=%b/%b expected=%b/%b", t,
                     icache_state, dcache_state, model[1:0], model[3:2]);
        end
    endtask

    initial begin
        logic [31:0] held;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_size = 2'b10; req_wdata = '0; irq_taken = 1'b0; model = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk_state("R1");
        rd(8'h00, 32'h0, "R1");
        rd(8'h04, 32'h1022_0000, "R7");
        rd(8'h08, 32'h1822_0000, "R7");

        wr(8'h00, 32'h0000_000F); chk_state("R2");
        rd(8'h00, 32'h0000_000F, "R2");

        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'hFF9E_3FFF, "R6");
        wr(8'h00, 32'h0080_0000);
        rd(8'h00, 32'h0080_0000, "R6");

        wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h04, 32'h1022_0000, "R7");
        rd(8'h08, 32'h1822_0000, "R7");
        rd(8'h00, 32'h0080_0000, "R7");

        // R3: instruction cache freeze
        wr(8'h00, 32'h0000_0013); pulse_irq(); chk_state("R3");
        rd(8'h00, 32'h0000_0011, "R3");
        wr(8'h00, 32'h0000_0012); pulse_irq(); chk_state("R3");
        rd(8'h00, 32'h0000_0012, "R3");
        wr(8'h00, 32'h0000_0010); pulse_irq(); chk_state("R3");

        // R4: data cache freeze
        wr(8'h00, 32'h0000_002F); pulse_irq(); chk_state("R4");
        rd(8'h00, 32'h0000_0027, "R4");

        // R5: enables clear
        wr(8'h00, 32'h0000_000F); pulse_irq(); chk_state("R5");
        rd(8'h00, 32'h0000_000F, "R5");

        // R11: write and interrupt in the same cycle
        wr(8'h00, 32'h0000_003F, 1'b1); chk_state("R11");
        rd(8'h00, 32'h0000_0035, "R11");

        // R8: wrong sizes
        acc(1'b1, 8'h00, 2'b00, 32'h0000_0000, 1'b0, 32'h0, "");
        acc(1'b1, 8'h00, 2'b01, 32'h0000_0000, 1'b0, 32'h0, "");
        rd(8'h00, 32'h0000_0035, "R8");
        rd(8'h00, 32'h0000_0000, "R8", 2'b01);
        rd(8'h04, 32'h0000_0000, "R8", 2'b00);

        // R9: unmapped offsets
        wr(8'h0C, 32'h0000_0000); wr(8'h01, 32'h0000_0000);
        rd(8'h0C, 32'h0000_0000, "R9");
        rd(8'h00, 32'h0000_0035, "R9");

        // R10: data holds between reads
        rd(8'h04, 32'h1022_0000, "R10");
        held = 32'h1022_0000;
        wr(8'h00, 32'h0000_0003);
        repeat (2) @(negedge clk);
        n_tests++;
        if (rd_data !== held) begin
            n_fail++;
            $display("FAIL R10 hold actual=%h expected=%h", rd_data, held);
        end
        chk_state("R2");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog all actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule